// File: doc/BRIEF.md
# External Cache Master Bus Arbiter

This block decides when an external cache-controller master may take a processor bus whose address phase and data phase are separate tenures. The host bridge keeps ownership by default. The external master asks for the bus with an active-low request line. The block answers with two independent grants: an address-bus grant and a data-bus grant. A tenure counts as accepted when the master starts a transfer while it holds the address grant and the bus is free. After that, the master must drop its request for at least one cycle before it can be granted again. If it keeps the request asserted, the block refuses to grant and raises a violation flag.

Each accepted address tenure is owed one data tenure. The data grant is given only while no host data tenure is in progress, and it is held until the master signals that its data phase is finished. The number of accepted tenures still waiting for data is bounded by a parameter. While that bound is reached, new address grants are held back. A separate edge detector turns each tag-update request into a write-enable pulse that lasts exactly one cycle.

Top module: `ext_master_arbiter`

## Requirements
- R1: While rst_n is low, addr_gnt, data_gnt, req_err and tag_we are all 0.
- R2: addr_gnt rises only one cycle after a cycle in which ext_req_n was 0 (requesting) and addr_busy was 0. From idle, the grant appears one cycle after such a cycle, provided host_req was 0 (or the master is owed the bus) and fewer than MAX_PEND tenures are waiting for data.
- R3: If ext_req_n is 1 or addr_busy is 1 while addr_gnt is 1, addr_gnt is 0 in the next cycle.
- R4: A cycle with addr_gnt=1, ext_ts=1 and addr_busy=0 is an accepted tenure. addr_gnt is 0 in the next cycle. It stays 0 until ext_req_n has been sampled 1 for at least one cycle, and it can be granted again one cycle after the request returns.
- R5: After an accepted tenure, each cycle in which the request is still held (ext_req_n=0) is not treated as a new request. req_err is 1 in the following cycle, and addr_gnt stays 0.
- R6: When host_req and the external request are both present on an idle, free address bus, the host wins and no grant follows. The external master is then owed the bus: it is granted one cycle after the next free cycle in which it still requests, even if host_req is 1.
- R7: data_gnt rises only when an accepted tenure is outstanding and host_data_busy was 0 in the previous cycle. It is never given earlier than two cycles after the acceptance.
- R8: Once raised, data_gnt stays 1 until ext_data_done is sampled 1. It is 0 in the cycle after that, and the outstanding count drops by one.
- R9: While MAX_PEND accepted tenures are awaiting their data tenure, no new address grant is given.
- R10: tag_we is 1 for exactly one cycle, namely the cycle after each cycle in which tag_upd rises from 0 to 1.
- R11: ext_req_n is active-low. A value of 1 (the pulled-up, undriven level) means no request, so no address grant is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | External master bus request, active low |
| ext_ts | input | 1 | External master transfer start |
| host_req | input | 1 | Host bridge wants the address bus |
| addr_busy | input | 1 | Address bus currently busy |
| host_data_busy | input | 1 | Host data tenure in progress |
| ext_data_done | input | 1 | External master data tenure finished |
| tag_upd | input | 1 | Tag update request, level |
| addr_gnt | output | 1 | Address bus grant to external master |
| data_gnt | output | 1 | Data bus grant to external master |
| req_err | output | 1 | Request held through mandatory release cycle |
| tag_we | output | 1 | One-cycle tag write enable |

## Verification
Directed patterns cover the distinct cases in turn:
- a request against a busy bus versus a free bus separates the availability condition from the request itself;
- a request held straight through an acceptance versus one released for a cycle separates the violation path from a legal re-grant;
- a request colliding with host_req, followed by a repeat, shows host priority and then the owed grant;
- two accepted tenures with the host data phase kept busy reach the outstanding limit.

Randomized request, start, busy and done patterns are then compared each cycle against a bench cycle model. These mix mid-grant withdrawals, start pulses on busy cycles and overlapping data completions with new address tenures.

// File: rtl/ext_arb_pkg.sv
package ext_arb_pkg;
  typedef enum logic [1:0] {
    AS_IDLE    = 2'd0,
    AS_GRANT   = 2'd1,
    AS_RELEASE = 2'd2
  } addr_st_e;
endpackage

// File: rtl/ext_arb_addr_seq.sv
module ext_arb_addr_seq
  import ext_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic busy,
  input  logic host_req,
  input  logic ts,
  input  logic room,
  output logic addr_gnt,
  output logic qual,
  output logic req_err
);
  addr_st_e st_q, st_d;
  logic     owed_q, owed_d;
  logic     err_d, err_q;
  logic     go;

  // grant from idle: master asks, bus free, space for another data tenure,
  // and either the host is not asking or the master is owed a turn
  assign go   = req && !busy && room && (!host_req || owed_q);
  assign qual = (st_q == AS_GRANT) && ts && !busy;

  always_comb begin
    st_d   = st_q;
    owed_d = owed_q;
    unique case (st_q)
      AS_IDLE: begin
        if (!req) begin
          owed_d = 1'b0;
        end else if (go) begin
          st_d   = AS_GRANT;
          owed_d = 1'b0;
        end else if (!busy && room && host_req) begin
          owed_d = 1'b1;
        end
      end
      AS_GRANT: begin
        owed_d = 1'b0;
        if (qual)              st_d = AS_RELEASE;
        else if (!req || busy) st_d = AS_IDLE;
      end
      AS_RELEASE: begin
        owed_d = 1'b0;
        if (!req) st_d = AS_IDLE;
      end
      default: begin
        st_d   = AS_IDLE;
        owed_d = 1'b0;
      end
    endcase
    err_d = (st_q == AS_RELEASE) && req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= AS_IDLE;
      owed_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      owed_q <= owed_d;
      err_q  <= err_d;
    end
  end

  assign addr_gnt = (st_q == AS_GRANT);
  assign req_err  = err_q;
endmodule

// File: rtl/ext_arb_data_trk.sv
module ext_arb_data_trk #(
  parameter int MAX_PEND = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  input  logic host_data_busy,
  input  logic data_done,
  output logic data_gnt,
  output logic room
);
  localparam int CNT_W = $clog2(MAX_PEND + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PEND);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] pend_q, pend_d;
  logic             dg_q, dg_d;
  logic             retire;
  logic             cnt_en;

  assign retire = dg_q && data_done;
  assign cnt_en = qual ^ retire;

  always_comb begin
    pend_d = pend_q;
    if (qual && !retire)      pend_d = pend_q + CNT_ONE;
    else if (!qual && retire) pend_d = pend_q - CNT_ONE;
    if (dg_q) dg_d = !data_done;
    else      dg_d = (pend_q != '0) && !host_data_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      dg_q   <= 1'b0;
    end else begin
      if (cnt_en) pend_q <= pend_d;
      dg_q <= dg_d;
    end
  end

  assign room     = (pend_q < CNT_MAX);
  assign data_gnt = dg_q;
endmodule

// File: rtl/ext_arb_tag_strobe.sv
module ext_arb_tag_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_upd,
  output logic tag_we
);
  logic upd_q, we_q, we_d;

  assign we_d = tag_upd && !upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      upd_q <= tag_upd;
      we_q  <= we_d;
    end
  end

  assign tag_we = we_q;
endmodule

// File: rtl/ext_master_arbiter.sv
module ext_master_arbiter #(
  parameter int MAX_PEND = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req_n,
  input  logic ext_ts,
  input  logic host_req,
  input  logic addr_busy,
  input  logic host_data_busy,
  input  logic ext_data_done,
  input  logic tag_upd,
  output logic addr_gnt,
  output logic data_gnt,
  output logic req_err,
  output logic tag_we
);
  logic req_act;
  logic qual;
  logic room;

  assign req_act = !ext_req_n;

  ext_arb_addr_seq u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req_act),
    .busy     (addr_busy),
    .host_req (host_req),
    .ts       (ext_ts),
    .room     (room),
    .addr_gnt (addr_gnt),
    .qual     (qual),
    .req_err  (req_err)
  );

  ext_arb_data_trk #(.MAX_PEND(MAX_PEND)) u_data (
    .clk            (clk),
    .rst_n          (rst_n),
    .qual           (qual),
    .host_data_busy (host_data_busy),
    .data_done      (ext_data_done),
    .data_gnt       (data_gnt),
    .room           (room)
  );

  ext_arb_tag_strobe u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag_upd (tag_upd),
    .tag_we  (tag_we)
  );
endmodule

// File: rtl/ext_master_arbiter_chk.sv
module ext_master_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic ext_req_n,
  input logic ext_ts,
  input logic addr_busy,
  input logic host_data_busy,
  input logic ext_data_done,
  input logic addr_gnt,
  input logic data_gnt,
  input logic req_err,
  input logic tag_we
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!addr_gnt && !data_gnt && !req_err && !tag_we);
    end
  end

  // R2
  gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_gnt) |-> $past(!ext_req_n && !addr_busy));

  // R3
  gnt_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_gnt && (ext_req_n || addr_busy)) |=> !addr_gnt);

  // R4
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_gnt && ext_ts && !addr_busy) |=> !addr_gnt);

  // R5
  held_req_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !addr_gnt);

  // R7
  dgnt_host_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_gnt) |-> $past(!host_data_busy));

  // R8
  dgnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_gnt && !ext_data_done) |=> data_gnt);

  // R10
  tag_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> !tag_we);
endmodule

bind ext_master_arbiter ext_master_arbiter_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ext_req_n      (ext_req_n),
  .ext_ts         (ext_ts),
  .addr_busy      (addr_busy),
  .host_data_busy (host_data_busy),
  .ext_data_done  (ext_data_done),
  .addr_gnt       (addr_gnt),
  .data_gnt       (data_gnt),
  .req_err        (req_err),
  .tag_we         (tag_we)
);

// File: tb/ext_master_arbiter_bench.sv
module ext_master_arbiter_bench;
  localparam int MAXP = 2;

  logic clk;
  logic rst_n;
  logic ext_req_n, ext_ts, host_req, addr_busy, host_data_busy, ext_data_done, tag_upd;
  logic addr_gnt, data_gnt, req_err, tag_we;

  int checks;
  int errors;
  bit finished;

  // reference model state
  int m_st;   // 0 idle, 1 grant, 2 release
  bit m_owed, m_dg, m_err, m_tw, m_tq;
  int m_pend;

  ext_master_arbiter #(.MAX_PEND(MAXP)) u_ext_master_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .ext_ts(ext_ts),
    .host_req(host_req), .addr_busy(addr_busy), .host_data_busy(host_data_busy),
    .ext_data_done(ext_data_done), .tag_upd(tag_upd), .addr_gnt(addr_gnt),
    .data_gnt(data_gnt), .req_err(req_err), .tag_we(tag_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit exp_go(bit req, bit busy, bit hreq, bit owed, int pend);
    return req && !busy && (pend < MAXP) && (!hreq || owed);
  endfunction

  task automatic check(string req_tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req_tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_owed = 0; m_dg = 0; m_err = 0; m_tw = 0; m_tq = 0; m_pend = 0;
  endtask

  task automatic model_tick();
    bit req, qual, retire, go, n_owed, n_dg;
    int n_st;
    req    = !ext_req_n;
    qual   = (m_st == 1) && ext_ts && !addr_busy;
    retire = m_dg && ext_data_done;
    go     = exp_go(req, addr_busy, host_req, m_owed, m_pend);
    n_st   = m_st;
    n_owed = 0;
    if (m_st == 0) begin
      n_owed = m_owed;
      if (!req) n_owed = 0;
      else if (go) begin n_st = 1; n_owed = 0; end
      else if (!addr_busy && (m_pend < MAXP) && host_req) n_owed = 1;
    end else if (m_st == 1) begin
      if (qual) n_st = 2;
      else if (!req || addr_busy) n_st = 0;
    end else begin
      if (!req) n_st = 0;
    end
    m_err = (m_st == 2) && req;
    n_dg  = m_dg ? !ext_data_done : ((m_pend > 0) && !host_data_busy);
    m_pend = m_pend + (qual ? 1 : 0) - (retire ? 1 : 0);
    m_dg = n_dg;
    m_st = n_st;
    m_owed = n_owed;
    m_tw = tag_upd && !m_tq;
    m_tq = tag_upd;
  endtask

  // one clock: model follows the edge, outputs sampled 2 ns later
  task automatic step();
    @(posedge clk);
    model_tick();
    #2;
    check("R2", "addr_gnt model", addr_gnt, (m_st == 1));
    check("R7", "data_gnt model", data_gnt, m_dg);
    check("R5", "req_err model",  req_err,  m_err);
    check("R10", "tag_we model",  tag_we,   m_tw);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    void'($urandom(32'd7719));
    rst_n = 1'b0;
    ext_req_n = 1'b1; ext_ts = 0; host_req = 0; addr_busy = 0;
    host_data_busy = 0; ext_data_done = 0; tag_upd = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check("R1", "addr_gnt in reset", addr_gnt, 1'b0);
    check("R1", "data_gnt in reset", data_gnt, 1'b0);
    check("R1", "req_err in reset",  req_err,  1'b0);
    check("R1", "tag_we in reset",   tag_we,   1'b0);
    rst_n = 1'b1;

    // R11: undriven (high) request never grants
    repeat (3) step();
    check("R11", "no grant while ext_req_n=1", addr_gnt, 1'b0);

    // R2: busy bus blocks, free bus grants
    ext_req_n = 0; addr_busy = 1; step();
    check("R2", "grant with busy bus", addr_gnt, 1'b0);
    addr_busy = 0; step();
    check("R2", "grant on free bus", addr_gnt, 1'b1);

    // R3: release withdraws
    ext_req_n = 1; step();
    check("R3", "withdraw on release", addr_gnt, 1'b0);

    // R4/R5 with host data busy to hold data grant off (R7)
    host_data_busy = 1;
    ext_req_n = 0; step();
    check("R4", "grant before accept", addr_gnt, 1'b1);
    ext_ts = 1; step();
    check("R4", "drop after accept", addr_gnt, 1'b0);
    ext_ts = 0; step();
    check("R5", "held request flagged", req_err, 1'b1);
    check("R5", "held request no grant", addr_gnt, 1'b0);
    step();
    check("R5", "still held no grant", addr_gnt, 1'b0);
    check("R7", "no data grant while host data busy", data_gnt, 1'b0);
    ext_req_n = 1; step();
    check("R5", "flag clears after release", req_err, 1'b0);
    ext_req_n = 0; step();
    check("R4", "regrant after release", addr_gnt, 1'b1);
    ext_req_n = 1; step();

    // R7/R8 data tenure
    host_data_busy = 0; step();
    check("R7", "data grant once host free", data_gnt, 1'b1);
    host_data_busy = 1; step(); step();
    check("R8", "data grant held until done", data_gnt, 1'b1);
    ext_data_done = 1; step();
    check("R8", "data grant drops after done", data_gnt, 1'b0);
    ext_data_done = 0; host_data_busy = 0; step();
    check("R8", "no data grant with nothing outstanding", data_gnt, 1'b0);

    // R6 host priority then owed grant
    ext_req_n = 0; host_req = 1; step();
    check("R6", "host wins collision", addr_gnt, 1'b0);
    step();
    check("R6", "owed master granted", addr_gnt, 1'b1);
    ext_req_n = 1; host_req = 0; step();

    // R9 outstanding limit
    host_data_busy = 1;
    for (int k = 0; k < MAXP; k++) begin
      ext_req_n = 0; step();
      ext_ts = 1; step();
      ext_ts = 0; ext_req_n = 1; step();
    end
    ext_req_n = 0; step(); step();
    check("R9", "no grant at outstanding limit", addr_gnt, 1'b0);
    ext_req_n = 1; host_data_busy = 0; ext_data_done = 1;
    repeat (6) step();
    ext_data_done = 0; step();

    // R10 tag strobe
    tag_upd = 1; step();
    check("R10", "tag pulse on rise", tag_we, 1'b1);
    step();
    check("R10", "tag pulse one cycle", tag_we, 1'b0);
    tag_upd = 0; step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      ext_req_n      = ($urandom_range(0, 99) < 40);
      ext_ts         = ($urandom_range(0, 99) < 35);
      host_req       = ($urandom_range(0, 99) < 30);
      addr_busy      = ($urandom_range(0, 99) < 25);
      host_data_busy = ($urandom_range(0, 99) < 40);
      ext_data_done  = ($urandom_range(0, 99) < 30);
      tag_upd        = ($urandom_range(0, 99) < 50);
      step();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule